// File: doc/BRIEF.md
# GPIO Port Controller with Pin Interrupts

The block controls one general-purpose I/O port of up to eight pins. Each pin has a 32-byte register window on a simple 32-bit read/write bus. The window holds the pin's configuration, a debounce threshold, the filtered input level, a tri-state ("floated") control, the output value and a write-one-to-clear interrupt acknowledge. A port-wide status word at byte address 0x104 shows which pins have a pending interrupt.

Each pad input passes through a two-flop synchronizer and then a debounce filter. The filtered level feeds an event detector. That detector can look for a high or low level, a rising or falling edge, or both edges. An event latches a pending flag for the pin. The single port interrupt line is the OR, over all pins, of each pending flag gated by that pin's interrupt enable. On the output side, a pin drives its pad only when it is enabled, set to output and not floated.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is 0, `irq` is 0 and the status word is 0.
- R2: Pin n's window starts at byte address n*0x20. Offsets within the window are: 0x00 config, 0x04 debounce threshold (8 bits), 0x08 filtered input (bit0, read-only), 0x0C floated (bit0), 0x10 output value (bit0) and 0x14 clear. The config word places enable at bit0, output direction at bit1, trigger type at bits[3:2], polarity at bit4 and interrupt enable at bit6. Its unimplemented bits read 0.
- R3: `pad_oe[n]` is 1 only when the pin is enabled, its direction bit is 1 and it is not floated. `pad_out[n]` follows output value bit0.
- R4: A floated bit of 1 forces `pad_oe[n]` to 0 even when the pin is an enabled output.
- R5: The input path has two synchronizer flops. With a threshold of 0, the filtered level read at offset 0x08 changes on the third rising clock edge after the pad changes.
- R6: With a threshold T>0, a new synchronized level is accepted on the (T+1)th consecutive clock cycle in which it differs from the filtered level. A pulse of T cycles or fewer is rejected.
- R7: Trigger type 2 is single edge: polarity 1 senses rising edges and polarity 0 senses falling edges. Type 3 senses both edges and ignores polarity. An edge sets a pending flag that stays set until it is cleared.
- R8: Trigger type 1 is level: polarity 1 is active-high and polarity 0 is active-low. While the level remains active, the pending flag stays set even after a clear.
- R9: Writing 1 in bit0 at offset 0x14 clears that pin's pending flag, and writing 0 there has no effect. If a clear and a new event fall in the same cycle, the pending flag stays set.
- R10: `irq` is the OR over all pins of (pending AND interrupt enable). The interrupt enable does not gate the latching of the pending flag.
- R11: A pin with its enable bit at 0, or with trigger type 0, never sets its pending flag.
- R12: The status word at 0x104 has bit n equal to pin n's pending flag. Undefined offsets, such as 0x18 in a pin window or 0x100 and 0x108, read 0. Writes to them, and writes to 0x104, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 9 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_out | output | NPINS | Output value per pin |
| pad_oe | output | NPINS | Pad driver enable per pin |
| irq | output | 1 | Port interrupt |

## Verification
Two functions can fall in the same cycle: a software clear of a pin's pending flag, and a fresh edge event on that same pin. The bench provokes this with a zero threshold. It changes the pad and then counts clock edges so that the clear write is sampled on exactly the edge where the detected rising edge is registered. The result is judged by reading the status word afterwards, which must still show the pin pending. A separate clear with no event present must then empty it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W   = 9;
    localparam int DATA_W   = 32;
    localparam int MAX_PINS = 8;

    localparam logic [4:0] OFS_CFG = 5'h00;
    localparam logic [4:0] OFS_DEB = 5'h04;
    localparam logic [4:0] OFS_IN  = 5'h08;
    localparam logic [4:0] OFS_FLT = 5'h0C;
    localparam logic [4:0] OFS_OUT = 5'h10;
    localparam logic [4:0] OFS_CLR = 5'h14;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 9'h104;

    typedef enum logic [1:0] {
        TRIG_NONE     = 2'd0,
        TRIG_LEVEL    = 2'd1,
        TRIG_ONE_EDGE = 2'd2,
        TRIG_TWO_EDGE = 2'd3
    } trig_e;

    typedef struct packed {
        logic  irq_en;
        logic  polarity;
        trig_e trig;
        logic  is_out;
        logic  enable;
    } pin_cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CFG, SEL_DEB, SEL_IN, SEL_FLT, SEL_OUT, SEL_CLR, SEL_STAT
    } sel_e;

    typedef struct packed {
        sel_e       sel;
        logic [2:0] pin;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a, input int npins);
        dec_t d;
        d.sel = SEL_NONE;
        d.pin = a[7:5];
        if (a == STATUS_ADDR) begin
            d.sel = SEL_STAT;
        end else if (!a[8] && (int'(a[7:5]) < npins)) begin
            case (a[4:0])
                OFS_CFG: d.sel = SEL_CFG;
                OFS_DEB: d.sel = SEL_DEB;
                OFS_IN:  d.sel = SEL_IN;
                OFS_FLT: d.sel = SEL_FLT;
                OFS_OUT: d.sel = SEL_OUT;
                OFS_CLR: d.sel = SEL_CLR;
                default: d.sel = SEL_NONE;
            endcase
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input pin_cfg_t c);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[0]   = c.enable;
        w[1]   = c.is_out;
        w[3:2] = c.trig;
        w[4]   = c.polarity;
        w[6]   = c.irq_en;
        return w;
    endfunction

    function automatic pin_cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        pin_cfg_t c;
        c.enable   = w[0];
        c.is_out   = w[1];
        c.trig     = trig_e'(w[3:2]);
        c.polarity = w[4];
        c.irq_en   = w[6];
        return c;
    endfunction

    // Event qualifier for one pin: level or edge of the filtered input.
    function automatic logic trig_hit(input pin_cfg_t c, input logic lvl, input logic prev);
        logic hit;
        hit = 1'b0;
        if (c.enable) begin
            case (c.trig)
                TRIG_LEVEL:    hit = (lvl == c.polarity);
                TRIG_ONE_EDGE: hit = c.polarity ? (lvl & ~prev) : (~lvl & prev);
                TRIG_TWO_EDGE: hit = lvl ^ prev;
                default:       hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int DB_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic [NPINS-1:0]           level_i,
    input  logic [NPINS-1:0]           pend_i,
    output pin_cfg_t [NPINS-1:0]       cfg_o,
    output logic [NPINS-1:0][DB_W-1:0] thr_o,
    output logic [NPINS-1:0]           flt_o,
    output logic [NPINS-1:0]           oval_o,
    output logic [NPINS-1:0]           clr_o
);

    dec_t d;
    logic unused_ok;

    assign d         = decode(addr, NPINS);
    assign unused_ok = ^wdata[DATA_W-1:DB_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o  <= '0;
            thr_o  <= '0;
            flt_o  <= '0;
            oval_o <= '0;
        end else if (wr_en) begin
            case (d.sel)
                SEL_CFG: cfg_o[d.pin]  <= word_to_cfg(wdata);
                SEL_DEB: thr_o[d.pin]  <= wdata[DB_W-1:0];
                SEL_FLT: flt_o[d.pin]  <= wdata[0];
                SEL_OUT: oval_o[d.pin] <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_o = '0;
        if (wr_en && (d.sel == SEL_CLR) && wdata[0]) begin
            clr_o[d.pin] = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        case (d.sel)
            SEL_CFG:  rdata = cfg_to_word(cfg_o[d.pin]);
            SEL_DEB:  rdata[DB_W-1:0] = thr_o[d.pin];
            SEL_IN:   rdata[0] = level_i[d.pin];
            SEL_FLT:  rdata[0] = flt_o[d.pin];
            SEL_OUT:  rdata[0] = oval_o[d.pin];
            SEL_STAT: rdata[NPINS-1:0] = pend_i;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pin_in.sv
module gpio_pin_in
    import gpio_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pad_i,
    input  logic [DB_W-1:0] thr_i,
    input  pin_cfg_t        cfg_i,
    input  logic            clr_i,
    output logic            level_o,
    output logic            pend_o
);

    logic            sync1, sync2;
    logic            prev;
    logic [DB_W-1:0] cnt;
    logic            hit;

    assign hit = trig_hit(cfg_i, level_o, prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1   <= 1'b0;
            sync2   <= 1'b0;
            level_o <= 1'b0;
            prev    <= 1'b0;
            cnt     <= '0;
            pend_o  <= 1'b0;
        end else begin
            sync1 <= pad_i;
            sync2 <= sync1;
            prev  <= level_o;
            // Accept a new level once it has differed for thr_i+1 cycles.
            if (sync2 == level_o) begin
                cnt <= '0;
            end else if (cnt >= thr_i) begin
                level_o <= sync2;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            // A new event outranks a clear in the same cycle.
            pend_o <= (pend_o & ~clr_i) | hit;
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int DB_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);

    pin_cfg_t [NPINS-1:0]       cfg;
    logic [NPINS-1:0][DB_W-1:0] thr;
    logic [NPINS-1:0]           flt, oval, clr;
    logic [NPINS-1:0]           level_vec, pend_vec, en_vec, ie_vec;

    gpio_regs #(.NPINS(NPINS), .DB_W(DB_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .level_i (level_vec),
        .pend_i  (pend_vec),
        .cfg_o   (cfg),
        .thr_o   (thr),
        .flt_o   (flt),
        .oval_o  (oval),
        .clr_o   (clr)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_pin_in #(.DB_W(DB_W)) pin_i (
            .clk     (clk),
            .rst     (rst),
            .pad_i   (pad_in[g]),
            .thr_i   (thr[g]),
            .cfg_i   (cfg[g]),
            .clr_i   (clr[g]),
            .level_o (level_vec[g]),
            .pend_o  (pend_vec[g])
        );
        assign en_vec[g] = cfg[g].enable;
        assign ie_vec[g] = cfg[g].irq_en;
        assign pad_oe[g] = cfg[g].enable & cfg[g].is_out & ~flt[g];
    end

    assign pad_out = oval;
    assign irq     = |(pend_vec & ie_vec);

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [8:0]       addr,
    input logic             wbit,
    input logic [NPINS-1:0] pad_oe,
    input logic             irq,
    input logic [NPINS-1:0] pend,
    input logic [NPINS-1:0] en_vec
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && pad_oe == '0));

    p_irq_has_source_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pend != '0));

    for (genvar k = 0; k < NPINS; k++) begin : g_k
        localparam logic [8:0] CLR_A = 9'(k * 32 + 20);
        localparam logic [8:0] FLT_A = 9'(k * 32 + 12);
        logic clr_k;
        assign clr_k = wr_en && (addr == CLR_A) && wbit;

        p_float_off_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == FLT_A && wbit) |=> !pad_oe[k]);

        p_pend_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            (pend[k] && !clr_k) |=> pend[k]);

        p_disabled_idle_r11: assert property (@(posedge clk) disable iff (rst)
            (!en_vec[k] && !pend[k]) |=> !pend[k]);
    end

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wbit   (wdata[0]),
    .pad_oe (pad_oe),
    .irq    (irq),
    .pend   (pend_vec),
    .en_vec (en_vec)
);

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_port_ctrl #(.NPINS(8), .DB_W(8)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    function automatic logic [8:0] pa(input int pin, input int ofs);
        return 9'(pin * 32 + ofs);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stat_bit(input string req, input int pin, input logic exp);
        logic [31:0] d;
        rd(9'h104, d);
        chk(req, 32'(d[pin]), 32'(exp));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(pa(0, 0), d);     chk("R1 cfg", d, 0);
        rd(pa(3, 4), d);     chk("R1 thr", d, 0);
        rd(9'h104, d);       chk("R1 status", d, 0);
        chk("R1 pad_oe", 32'(pad_oe), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        wr(pa(5, 0), 32'hFFFF_FFFF);
        rd(pa(5, 0), d);  chk("R2 cfg bits", d, 32'h5F);
        wr(pa(5, 0), 32'h0);
        wr(pa(5, 4), 32'h1A5);
        rd(pa(5, 4), d);  chk("R2 thr width", d, 32'hA5);
        wr(pa(7, 4), 32'h33);
        rd(pa(7, 4), d);  chk("R2 window 7", d, 32'h33);
        rd(pa(6, 4), d);  chk("R2 window 6", d, 0);
        wr(pa(5, 4), 32'h0);
    endtask

    task automatic t_undefined;
        logic [31:0] d;
        wr(pa(0, 24), 32'hFFFF_FFFF);
        rd(pa(0, 24), d); chk("R12 undef read", d, 0);
        rd(pa(0, 0), d);  chk("R12 undef write ignored", d, 0);
        wr(9'h100, 32'hFFFF_FFFF);
        rd(9'h100, d);    chk("R12 0x100 reads 0", d, 0);
        wr(9'h104, 32'hFF);
        rd(9'h104, d);    chk("R12 status not writable", d, 0);
        rd(9'h108, d);    chk("R12 0x108 reads 0", d, 0);
    endtask

    task automatic t_output;
        wr(pa(2, 16), 32'h1);
        wr(pa(2, 0), 32'h3);
        #1 chk("R3 oe enabled output", 32'(pad_oe[2]), 1);
        chk("R3 out value", 32'(pad_out[2]), 1);
        wr(pa(2, 12), 32'h1);
        #1 chk("R4 floated output", 32'(pad_oe[2]), 0);
        wr(pa(2, 12), 32'h0);
        #1 chk("R4 unfloated", 32'(pad_oe[2]), 1);
        wr(pa(2, 16), 32'h0);
        #1 chk("R3 out value low", 32'(pad_out[2]), 0);
        wr(pa(2, 0), 32'h1);
        #1 chk("R3 input no drive", 32'(pad_oe[2]), 0);
        wr(pa(2, 0), 32'h2);
        #1 chk("R3 disabled no drive", 32'(pad_oe[2]), 0);
        wr(pa(2, 0), 32'h0);
    endtask

    task automatic t_debounce;
        // threshold 0: visible after edge 3
        @(negedge clk); addr = pa(2, 8);
        @(negedge clk); pad_in[2] = 1'b1;
        repeat (2) @(negedge clk);
        #1 chk("R5 thr0 before", 32'(rdata[0]), 0);
        @(negedge clk);
        #1 chk("R5 thr0 at edge3", 32'(rdata[0]), 1);
        // threshold 3: visible after edge 6
        wr(pa(7, 4), 32'h3);
        @(negedge clk); addr = pa(7, 8);
        @(negedge clk); pad_in[7] = 1'b1;
        repeat (5) @(negedge clk);
        #1 chk("R6 thr3 before", 32'(rdata[0]), 0);
        @(negedge clk);
        #1 chk("R6 thr3 at edge6", 32'(rdata[0]), 1);
        // 3-cycle low glitch rejected
        idle(4);
        pad_in[7] = 1'b0;
        repeat (3) @(negedge clk);
        pad_in[7] = 1'b1;
        idle(10);
        #1 chk("R6 glitch rejected", 32'(rdata[0]), 1);
    endtask

    task automatic t_edges;
        wr(pa(1, 0), 32'h19);            // enable, single edge, rising
        pad_in[1] = 1'b1; idle(8);
        stat_bit("R7 rising sets", 1, 1);
        wr(pa(1, 20), 32'h0);
        stat_bit("R9 write 0 no clear", 1, 1);
        wr(pa(1, 20), 32'h1); idle(4);
        stat_bit("R7 cleared, no re-trigger", 1, 0);
        wr(pa(1, 0), 32'h09);            // falling
        pad_in[1] = 1'b0; idle(8);
        stat_bit("R7 falling sets", 1, 1);
        wr(pa(1, 20), 32'h1);
        pad_in[1] = 1'b1; idle(8);
        stat_bit("R7 falling ignores rise", 1, 0);
        wr(pa(1, 0), 32'h0D);            // both edges, polarity 0
        pad_in[1] = 1'b0; idle(8);
        stat_bit("R7 both fall", 1, 1);
        wr(pa(1, 20), 32'h1);
        pad_in[1] = 1'b1; idle(8);
        stat_bit("R7 both rise", 1, 1);
        wr(pa(1, 20), 32'h1);
        wr(pa(1, 0), 32'h0);
    endtask

    task automatic t_level;
        wr(pa(3, 0), 32'h15);            // level, active high
        pad_in[3] = 1'b1; idle(8);
        stat_bit("R8 high level sets", 3, 1);
        wr(pa(3, 20), 32'h1);
        stat_bit("R8 stays while active", 3, 1);
        pad_in[3] = 1'b0; idle(8);
        wr(pa(3, 20), 32'h1); idle(2);
        stat_bit("R8 clears when inactive", 3, 0);
        wr(pa(3, 0), 32'h05);            // level, active low, pad is low
        idle(3);
        stat_bit("R8 low level sets", 3, 1);
        wr(pa(3, 0), 32'h0);
        wr(pa(3, 20), 32'h1);
        stat_bit("R9 clear", 3, 0);
    endtask

    task automatic t_irq;
        wr(pa(6, 0), 32'h19);
        pad_in[6] = 1'b1; idle(8);
        stat_bit("R10 pending without enable", 6, 1);
        chk("R10 irq masked", 32'(irq), 0);
        wr(pa(6, 0), 32'h59);
        #1 chk("R10 irq enabled", 32'(irq), 1);
        wr(pa(6, 20), 32'h1);
        #1 chk("R10 irq after clear", 32'(irq), 0);
        wr(pa(6, 0), 32'h0);
    endtask

    task automatic t_disabled;
        wr(pa(4, 0), 32'h18);            // rising edge but not enabled
        pad_in[4] = 1'b1; idle(8);
        stat_bit("R11 disabled pin", 4, 0);
        wr(pa(4, 0), 32'h11);            // enabled, trigger none
        pad_in[4] = 1'b0; idle(8);
        stat_bit("R11 trigger none", 4, 0);
        wr(pa(4, 0), 32'h0);
    endtask

    task automatic t_clear_race;
        wr(pa(0, 0), 32'h19);
        pad_in[0] = 1'b1; idle(8);
        pad_in[0] = 1'b0; idle(8);
        stat_bit("R9 race setup", 0, 1);
        @(negedge clk); pad_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        wr(pa(0, 20), 32'h1);            // sampled on the edge that registers the rise
        stat_bit("R9 event beats clear", 0, 1);
        wr(pa(0, 20), 32'h1);
        stat_bit("R9 plain clear", 0, 0);
        wr(pa(0, 0), 32'h0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_regmap();
        t_undefined();
        t_output();
        t_debounce();
        t_edges();
        t_level();
        t_irq();
        t_disabled();
        t_clear_race();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule